// File: doc/BRIEF.md
# Posted-Write / Stalled-Read Bus Transaction Queue

This block sits between the slave side of an internal shared bus and a DRAM controller. Burst writes from the bus are posted into a small write store. Each beat is acknowledged as soon as it is buffered, so the bus master finishes before the data reaches memory. Reads are never answered with a split or retry. The read beat stays on the bus, and the slave inserts wait states until the controller has returned the matching data word.

On the controller side the queue presents one transaction at a time through a request/grant pair. A granted write hands over its whole line at once and frees its entry. A granted read then streams its words back through a line buffer, and that buffer feeds the bus beat by beat. A read that arrives behind queued writes stays stalled on the bus until every one of those writes has been granted. This keeps reads ordered after earlier writes.

Parameters set the address and data widths, the line size in beats, the number of write entries and an optional read-data bypass.

Top module: `mtq_top`

## Requirements
- R1: After reset, `ctl_req` is low and the write store is empty. The first beat of a write burst then sees `bus_ready` high in the same cycle it is presented.
- R2: A write burst of N beats, with entries free, completes on the bus in N cycles with no wait states. Completion does not wait for the controller grant.
- R3: At most DEPTH (default 2) writes are held. The first beat of a further write sees `bus_ready` low until a controller grant frees an entry. The write is then accepted.
- R4: An entry is offered to the controller only after its final beat. `ctl_len` is the beat count minus one. Beat i of the burst appears at bits [i*DW +: DW] of `ctl_wdata`.
- R5: Queued writes are offered to the controller in the order they arrived on the bus.
- R6: A read arriving while writes are queued or being filled is not requested from the controller until all of those writes have been granted. Until then `ctl_write` stays 1 and `bus_ready` stays low for the read.
- R7: A read beat is held with `bus_ready` low, and no other response, until its data word has arrived. The returned beats equal the controller words in order.
- R8: Only one read is in flight at a time. After a read grant, `ctl_req` stays low until that read completes on the bus. Writes plus reads outstanding never exceed DEPTH.
- R9: While `ctl_req` is high without `ctl_gnt`, the request and its `ctl_addr` and `ctl_write` hold steady into the next cycle.
- R10: With the bypass off (default), a read beat becomes ready in the cycle after its data word is captured from `ctl_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_valid | input | 1 | A bus beat is presented |
| bus_write | input | 1 | 1 = write beat, 0 = read beat |
| bus_first | input | 1 | First beat of a burst |
| bus_last | input | 1 | Final beat of a burst |
| bus_addr | input | AW | Burst start address (held for the burst) |
| bus_len | input | LW | Burst beats minus one (held for the burst) |
| bus_wdata | input | DW | Write data of this beat |
| bus_ready | output | 1 | Beat completes this cycle; low inserts a wait state |
| bus_rdata | output | DW | Read data of this beat |
| ctl_req | output | 1 | A transaction is offered to the controller |
| ctl_write | output | 1 | Offered transaction is a write |
| ctl_addr | output | AW | Offered start address |
| ctl_len | output | LW | Offered beats minus one |
| ctl_wdata | output | BEATS*DW | Whole write line, beat i at [i*DW +: DW] |
| ctl_gnt | input | 1 | Controller takes the offered transaction |
| ctl_rvalid | input | 1 | A read data word is returned |
| ctl_rdata | input | DW | Returned read data word |

## Verification
The hardest situation to reach is a read that is stalled behind two posted writes. The write store must be full, the read must already be holding the bus, and the controller must still be withholding its grants. The bench reaches it with two parallel threads. One thread acts as the bus master and queues two writes, then issues the read. The other acts as the controller and holds off all grants while it watches the stall and the head write for several cycles. It then grants the writes in turn and returns the read words only after a long delay.

// File: rtl/mtq_pkg.sv
package mtq_pkg;
   typedef enum logic [1:0] {
      RD_IDLE = 2'd0,
      RD_REQ  = 2'd1,
      RD_DATA = 2'd2
   } rd_state_e;

   function automatic int unsigned ptr_bits(input int unsigned n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/mtq_wbuf.sv
module mtq_wbuf #(
   parameter int AW    = 32,
   parameter int DW    = 32,
   parameter int BEATS = 8,
   parameter int DEPTH = 2
) (
   input  logic                                  clk,
   input  logic                                  rst_n,
   input  logic                                  beat_acc,
   input  logic                                  first,
   input  logic                                  last,
   input  logic [AW-1:0]                         addr,
   input  logic [mtq_pkg::ptr_bits(BEATS)-1:0]   len,
   input  logic [DW-1:0]                         wdata,
   input  logic                                  pop,
   output logic                                  can_start,
   output logic                                  filling,
   output logic                                  head_valid,
   output logic [AW-1:0]                         head_addr,
   output logic [mtq_pkg::ptr_bits(BEATS)-1:0]   head_len,
   output logic [BEATS*DW-1:0]                   head_data,
   output logic [$clog2(DEPTH+1)-1:0]            count
);
   localparam int LW   = mtq_pkg::ptr_bits(BEATS);
   localparam int PW   = mtq_pkg::ptr_bits(DEPTH);
   localparam int CW   = $clog2(DEPTH+1);
   localparam int LINE = BEATS*DW;

   logic [PW-1:0]   head, tail;
   logic [LW-1:0]   bidx, slot;
   logic            push;
   logic            vld    [DEPTH];
   logic [AW-1:0]   e_addr [DEPTH];
   logic [LW-1:0]   e_len  [DEPTH];
   logic [LINE-1:0] e_data [DEPTH];

   function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
      return (p == PW'(DEPTH-1)) ? '0 : p + 1'b1;
   endfunction

   assign slot      = first ? '0 : bidx;
   assign push      = beat_acc && last;
   assign can_start = (count < CW'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         filling <= 1'b0;
         bidx    <= '0;
      end else if (beat_acc) begin
         filling <= !last;
         bidx    <= slot + 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         head  <= '0;
         tail  <= '0;
         count <= '0;
      end else begin
         if (push) tail <= nxt(tail);
         if (pop)  head <= nxt(head);
         case ({push, pop})
            2'b10:   count <= count + 1'b1;
            2'b01:   count <= count - 1'b1;
            default: count <= count;
         endcase
      end
   end

   for (genvar e = 0; e < DEPTH; e++) begin : g_entry
      always_ff @(posedge clk) begin
         if (beat_acc && tail == PW'(e)) begin
            if (first) begin
               e_addr[e] <= addr;
               e_len[e]  <= len;
            end
            e_data[e][slot*DW +: DW] <= wdata;
         end
      end

      always_ff @(posedge clk) begin
         if (!rst_n)
            vld[e] <= 1'b0;
         else if (push && tail == PW'(e))
            vld[e] <= 1'b1;
         else if (pop && head == PW'(e))
            vld[e] <= 1'b0;
      end
   end

   assign head_valid = vld[head];
   assign head_addr  = e_addr[head];
   assign head_len   = e_len[head];
   assign head_data  = e_data[head];
endmodule

// File: rtl/mtq_rdpath.sv
module mtq_rdpath #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int BEATS     = 8,
   parameter bit RD_BYPASS = 1'b0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                start,
   input  logic [AW-1:0]                       addr,
   input  logic [mtq_pkg::ptr_bits(BEATS)-1:0] len,
   input  logic                                gnt,
   input  logic                                rvalid,
   input  logic [DW-1:0]                       rdata,
   input  logic                                beat_acc,
   output logic                                req,
   output logic                                busy,
   output logic [AW-1:0]                       req_addr,
   output logic [mtq_pkg::ptr_bits(BEATS)-1:0] req_len,
   output logic                                beat_ready,
   output logic [DW-1:0]                       beat_data
);
   import mtq_pkg::*;
   localparam int LW = ptr_bits(BEATS);

   rd_state_e     state;
   logic [LW:0]   fill;
   logic [LW-1:0] k;
   logic [DW-1:0] rbuf [BEATS];
   logic          take, have;

   assign take = (state == RD_DATA) && rvalid && (fill <= {1'b0, req_len});
   assign req  = (state == RD_REQ);
   assign busy = (state != RD_IDLE);
   assign have = (state == RD_DATA) && (fill > {1'b0, k});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= RD_IDLE;
         fill  <= '0;
         k     <= '0;
      end else begin
         case (state)
            RD_IDLE: if (start) state <= RD_REQ;
            RD_REQ: if (gnt) begin
               state <= RD_DATA;
               fill  <= '0;
               k     <= '0;
            end
            RD_DATA: begin
               if (take) fill <= fill + 1'b1;
               if (beat_acc) begin
                  k <= k + 1'b1;
                  if (k == req_len) state <= RD_IDLE;
               end
            end
            default: state <= RD_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state == RD_IDLE && start) begin
         req_addr <= addr;
         req_len  <= len;
      end
   end

   always_ff @(posedge clk) begin
      if (take) rbuf[fill[LW-1:0]] <= rdata;
   end

   if (RD_BYPASS) begin : g_bypass
      logic fresh;
      assign fresh      = take && (fill == {1'b0, k});
      assign beat_ready = have || fresh;
      assign beat_data  = have ? rbuf[k] : rdata;
   end else begin : g_registered
      assign beat_ready = have;
      assign beat_data  = rbuf[k];
   end
endmodule

// File: rtl/mtq_issue.sv
module mtq_issue #(
   parameter int AW = 32,
   parameter int LW = 3
) (
   input  logic          wr_valid,
   input  logic [AW-1:0] wr_addr,
   input  logic [LW-1:0] wr_len,
   input  logic          rd_req,
   input  logic [AW-1:0] rd_addr,
   input  logic [LW-1:0] rd_len,
   input  logic          gnt,
   output logic          req,
   output logic          is_write,
   output logic [AW-1:0] addr,
   output logic [LW-1:0] len,
   output logic          wr_pop,
   output logic          rd_gnt
);
   always_comb begin
      req      = wr_valid || rd_req;
      is_write = wr_valid;
      addr     = wr_valid ? wr_addr : rd_addr;
      len      = wr_valid ? wr_len  : rd_len;
      wr_pop   = gnt && wr_valid;
      rd_gnt   = gnt && !wr_valid && rd_req;
   end
endmodule

// File: rtl/mtq_top.sv
module mtq_top #(
   parameter int AW        = 32,
   parameter int DW        = 32,
   parameter int BEATS     = 8,
   parameter int DEPTH     = 2,
   parameter bit RD_BYPASS = 1'b0
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic                                bus_valid,
   input  logic                                bus_write,
   input  logic                                bus_first,
   input  logic                                bus_last,
   input  logic [AW-1:0]                       bus_addr,
   input  logic [mtq_pkg::ptr_bits(BEATS)-1:0] bus_len,
   input  logic [DW-1:0]                       bus_wdata,
   output logic                                bus_ready,
   output logic [DW-1:0]                       bus_rdata,
   output logic                                ctl_req,
   output logic                                ctl_write,
   output logic [AW-1:0]                       ctl_addr,
   output logic [mtq_pkg::ptr_bits(BEATS)-1:0] ctl_len,
   output logic [BEATS*DW-1:0]                 ctl_wdata,
   input  logic                                ctl_gnt,
   input  logic                                ctl_rvalid,
   input  logic [DW-1:0]                       ctl_rdata
);
   localparam int LW = mtq_pkg::ptr_bits(BEATS);
   localparam int CW = $clog2(DEPTH+1);

   if (DEPTH < 1) begin : g_bad_depth
      $error("mtq_top: DEPTH must be at least 1");
   end
   if (DW < 8 || (DW % 8) != 0) begin : g_bad_dw
      $error("mtq_top: DW must be a whole number of bytes");
   end
   if (BEATS < 2 || BEATS != (1 << LW)) begin : g_bad_beats
      $error("mtq_top: BEATS must be a power of two of at least 2");
   end

   logic            wr_can, wr_filling, wr_head_v, wr_acc, wr_pop;
   logic [AW-1:0]   wr_head_addr, rd_addr;
   logic [LW-1:0]   wr_head_len, rd_len;
   logic [CW-1:0]   wq_count;
   logic            rd_req, rd_busy, rd_gnt, rd_start, rd_beat_rdy, rd_acc;
   logic            wr_rdy;

   assign wr_rdy    = wr_filling || (bus_first && wr_can && !rd_busy);
   assign bus_ready = bus_valid && (bus_write ? wr_rdy : rd_beat_rdy);
   assign wr_acc    = bus_ready && bus_write;
   assign rd_acc    = bus_ready && !bus_write;
   assign rd_start  = bus_valid && !bus_write && bus_first &&
                      (wq_count == '0) && !wr_filling;

   mtq_wbuf #(.AW(AW), .DW(DW), .BEATS(BEATS), .DEPTH(DEPTH)) u_wbuf (
      .clk(clk), .rst_n(rst_n), .beat_acc(wr_acc), .first(bus_first),
      .last(bus_last), .addr(bus_addr), .len(bus_len), .wdata(bus_wdata),
      .pop(wr_pop), .can_start(wr_can), .filling(wr_filling),
      .head_valid(wr_head_v), .head_addr(wr_head_addr), .head_len(wr_head_len),
      .head_data(ctl_wdata), .count(wq_count)
   );

   mtq_rdpath #(.AW(AW), .DW(DW), .BEATS(BEATS), .RD_BYPASS(RD_BYPASS)) u_rd (
      .clk(clk), .rst_n(rst_n), .start(rd_start), .addr(bus_addr),
      .len(bus_len), .gnt(rd_gnt), .rvalid(ctl_rvalid), .rdata(ctl_rdata),
      .beat_acc(rd_acc), .req(rd_req), .busy(rd_busy), .req_addr(rd_addr),
      .req_len(rd_len), .beat_ready(rd_beat_rdy), .beat_data(bus_rdata)
   );

   mtq_issue #(.AW(AW), .LW(LW)) u_issue (
      .wr_valid(wr_head_v), .wr_addr(wr_head_addr), .wr_len(wr_head_len),
      .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len), .gnt(ctl_gnt),
      .req(ctl_req), .is_write(ctl_write), .addr(ctl_addr), .len(ctl_len),
      .wr_pop(wr_pop), .rd_gnt(rd_gnt)
   );
endmodule

// File: rtl/mtq_chk.sv
module mtq_chk #(
   parameter int AW    = 32,
   parameter int DEPTH = 2
) (
   input logic                       clk,
   input logic                       rst_n,
   input logic                       bus_valid,
   input logic                       bus_write,
   input logic                       bus_first,
   input logic                       bus_last,
   input logic                       bus_ready,
   input logic                       ctl_req,
   input logic                       ctl_write,
   input logic [AW-1:0]              ctl_addr,
   input logic                       ctl_gnt,
   input logic [$clog2(DEPTH+1)-1:0] wq_count,
   input logic                       rd_busy,
   input logic                       wr_filling
);
   localparam int CW = $clog2(DEPTH+1);

   assert_full_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_write && bus_first && !wr_filling && wq_count == CW'(DEPTH)
      |-> !bus_ready);

   assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
      wq_count <= CW'(DEPTH));

   assert_entry_offered_R4: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && bus_write && bus_ready && bus_last |=> ctl_req && ctl_write);

   assert_read_after_writes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_req && !ctl_write |-> wq_count == '0 && !wr_filling);

   assert_read_waits_R7: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid && !bus_write && bus_ready |-> rd_busy);

   assert_single_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      rd_busy |-> wq_count == '0);

   assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_req && !ctl_gnt |=> ctl_req && $stable(ctl_addr) && $stable(ctl_write));
endmodule

bind mtq_top mtq_chk #(.AW(AW), .DEPTH(DEPTH)) u_chk (
   .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
   .bus_first(bus_first), .bus_last(bus_last), .bus_ready(bus_ready),
   .ctl_req(ctl_req), .ctl_write(ctl_write), .ctl_addr(ctl_addr),
   .ctl_gnt(ctl_gnt), .wq_count(wq_count), .rd_busy(rd_busy),
   .wr_filling(wr_filling)
);

// File: tb/sim_mtq_top.sv
module sim_mtq_top;
   localparam int PER   = 10;
   localparam int AW    = 32;
   localparam int DW    = 32;
   localparam int BEATS = 8;
   localparam int LW    = 3;

   typedef struct packed {
      logic        wr;
      logic [31:0] addr;
      logic [2:0]  len;
      logic [31:0] seed;
   } vec_t;

   localparam vec_t VEC [6] = '{
      '{1'b1, 32'h0000_1000, 3'd7, 32'hA000_0000},
      '{1'b0, 32'h0000_1000, 3'd7, 32'hB000_0100},
      '{1'b1, 32'h0000_2040, 3'd0, 32'h1234_5678},
      '{1'b0, 32'h0000_3000, 3'd0, 32'hC0DE_0000},
      '{1'b1, 32'h0000_4400, 3'd3, 32'h5555_0000},
      '{1'b0, 32'h0000_5000, 3'd5, 32'h0F0F_0000}
   };

   logic clk = 1'b0, rst_n = 1'b0;
   logic bus_valid = 0, bus_write = 0, bus_first = 0, bus_last = 0;
   logic [AW-1:0] bus_addr = '0;
   logic [LW-1:0] bus_len = '0;
   logic [DW-1:0] bus_wdata = '0;
   logic bus_ready;
   logic [DW-1:0] bus_rdata;
   logic ctl_req, ctl_write;
   logic [AW-1:0] ctl_addr;
   logic [LW-1:0] ctl_len;
   logic [BEATS*DW-1:0] ctl_wdata;
   logic ctl_gnt = 0, ctl_rvalid = 0;
   logic [DW-1:0] ctl_rdata = '0;

   int n_chk = 0, n_fail = 0, wait_cnt = 0;
   logic [DW-1:0] rd_got [BEATS];

   always #(PER/2) clk = ~clk;

   mtq_top #(.AW(AW), .DW(DW), .BEATS(BEATS), .DEPTH(2)) u0 (.*);

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   task automatic bus_beat(input logic wr, input logic fst, input logic lst,
                           input logic [AW-1:0] a, input logic [LW-1:0] l,
                           input logic [DW-1:0] d, output logic [DW-1:0] rd);
      bus_valid = 1; bus_write = wr; bus_first = fst; bus_last = lst;
      bus_addr = a; bus_len = l; bus_wdata = d;
      #1;
      while (!bus_ready) begin
         wait_cnt++;
         @(negedge clk); #1;
      end
      rd = bus_rdata;
      @(posedge clk);
      @(negedge clk);
      bus_valid = 0;
   endtask

   task automatic bus_write_burst(input logic [AW-1:0] a, input logic [LW-1:0] l,
                                  input logic [DW-1:0] seed);
      logic [DW-1:0] unused;
      for (int b = 0; b <= int'(l); b++)
         bus_beat(1'b1, b == 0, b == int'(l), a, l, seed + DW'(b), unused);
   endtask

   task automatic bus_read_burst(input logic [AW-1:0] a, input logic [LW-1:0] l);
      for (int b = 0; b <= int'(l); b++)
         bus_beat(1'b0, b == 0, b == int'(l), a, l, '0, rd_got[b]);
   endtask

   task automatic take_write(input string rq, input logic [AW-1:0] a,
                             input logic [LW-1:0] l, input logic [DW-1:0] seed);
      @(negedge clk); #1;
      while (!ctl_req) begin @(negedge clk); #1; end
      chk(ctl_write == 1'b1, rq, "ctl_write", 64'(ctl_write), 64'd1);
      chk(ctl_addr == a, rq, "write ctl_addr", 64'(ctl_addr), 64'(a));
      chk(ctl_len == l, "R4", "write ctl_len", 64'(ctl_len), 64'(l));
      for (int i = 0; i <= int'(l); i++)
         chk(ctl_wdata[i*DW +: DW] == seed + DW'(i), "R4", "line beat",
             64'(ctl_wdata[i*DW +: DW]), 64'(seed + DW'(i)));
      ctl_gnt = 1;
      @(posedge clk); #1;
      ctl_gnt = 0;
   endtask

   task automatic serve_read(input logic [AW-1:0] a, input logic [LW-1:0] l,
                             input logic [DW-1:0] seed, input int delay);
      @(negedge clk); #1;
      while (!(ctl_req && !ctl_write)) begin @(negedge clk); #1; end
      chk(ctl_addr == a, "R7", "read ctl_addr", 64'(ctl_addr), 64'(a));
      chk(ctl_len == l, "R7", "read ctl_len", 64'(ctl_len), 64'(l));
      ctl_gnt = 1;
      @(posedge clk); @(negedge clk);
      ctl_gnt = 0;
      #1;
      chk(ctl_req == 1'b0, "R8", "req after read grant", 64'(ctl_req), 64'd0);
      for (int d = 0; d < delay; d++) begin
         chk(bus_ready == 1'b0, "R7", "read wait state", 64'(bus_ready), 64'd0);
         @(negedge clk); #1;
      end
      for (int i = 0; i <= int'(l); i++) begin
         ctl_rvalid = 1; ctl_rdata = seed + DW'(i);
         @(posedge clk); @(negedge clk);
         ctl_rvalid = 0;
         #1;
         chk(bus_ready == 1'b1, "R10", "ready after word", 64'(bus_ready), 64'd1);
      end
   endtask

   task automatic check_read(input logic [LW-1:0] l, input logic [DW-1:0] seed);
      for (int i = 0; i <= int'(l); i++)
         chk(rd_got[i] == seed + DW'(i), "R7", "read beat",
             64'(rd_got[i]), 64'(seed + DW'(i)));
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   initial begin
      repeat (60000) @(posedge clk);
      chk(1'b0, "R1-watchdog", "cycles", 64'd60000, 64'd0);
      finish_run();
   end

   initial begin
      logic [DW-1:0] unused;
      repeat (3) @(negedge clk);
      chk(ctl_req == 1'b0, "R1", "ctl_req in reset", 64'(ctl_req), 64'd0);
      rst_n = 1;
      @(negedge clk); #1;
      chk(ctl_req == 1'b0, "R1", "ctl_req after reset", 64'(ctl_req), 64'd0);
      bus_valid = 1; bus_write = 1; bus_first = 1; bus_last = 1;
      #1;
      chk(bus_ready == 1'b1, "R1", "first write beat ready", 64'(bus_ready), 64'd1);
      bus_valid = 0;
      @(negedge clk);

      // table of transactions
      for (int v = 0; v < 6; v++) begin
         if (VEC[v].wr) begin
            wait_cnt = 0;
            bus_write_burst(VEC[v].addr, VEC[v].len, VEC[v].seed);
            chk(wait_cnt == 0, "R2", "posted write wait states", 64'(wait_cnt), 64'd0);
            take_write("R2", VEC[v].addr, VEC[v].len, VEC[v].seed);
         end else begin
            fork
               bus_read_burst(VEC[v].addr, VEC[v].len);
               serve_read(VEC[v].addr, VEC[v].len, VEC[v].seed, 3);
            join
            check_read(VEC[v].len, VEC[v].seed);
         end
         @(negedge clk);
      end

      // R3 / R5: full store stalls a third write; grants follow arrival order
      wait_cnt = 0;
      bus_write_burst(32'h0000_6000, 3'd0, 32'h6000_0000);
      bus_write_burst(32'h0000_7000, 3'd1, 32'h7000_0000);
      chk(wait_cnt == 0, "R2", "two writes posted", 64'(wait_cnt), 64'd0);
      fork
         bus_write_burst(32'h0000_8000, 3'd2, 32'h8000_0000);
         begin
            for (int c = 0; c < 5; c++) begin
               @(negedge clk); #1;
               chk(bus_ready == 1'b0, "R3", "third write stalled", 64'(bus_ready), 64'd0);
            end
            take_write("R5", 32'h0000_6000, 3'd0, 32'h6000_0000);
            take_write("R5", 32'h0000_7000, 3'd1, 32'h7000_0000);
            take_write("R3", 32'h0000_8000, 3'd2, 32'h8000_0000);
         end
      join
      @(negedge clk);

      // R6 / R7: read behind two queued writes, long data delay
      bus_write_burst(32'h0000_9000, 3'd1, 32'h9000_0000);
      bus_write_burst(32'h0000_A000, 3'd0, 32'hA0A0_0000);
      fork
         bus_read_burst(32'h0000_B000, 3'd3);
         begin
            for (int c = 0; c < 4; c++) begin
               @(negedge clk); #1;
               chk(ctl_req && ctl_write, "R6", "head is write", 64'(ctl_write), 64'd1);
               chk(ctl_addr == 32'h0000_9000, "R6", "head addr", 64'(ctl_addr), 64'h9000);
               chk(bus_ready == 1'b0, "R6", "read stalled", 64'(bus_ready), 64'd0);
            end
            take_write("R6", 32'h0000_9000, 3'd1, 32'h9000_0000);
            take_write("R6", 32'h0000_A000, 3'd0, 32'hA0A0_0000);
            serve_read(32'h0000_B000, 3'd3, 32'hBEEF_0000, 12);
         end
      join
      check_read(3'd3, 32'hBEEF_0000);
      @(negedge clk);

      // R4: entry held back until the final beat of a paused burst
      bus_beat(1'b1, 1'b1, 1'b0, 32'h0000_C000, 3'd3, 32'hC000_0000, unused);
      bus_beat(1'b1, 1'b0, 1'b0, 32'h0000_C000, 3'd3, 32'hC000_0001, unused);
      for (int c = 0; c < 3; c++) begin
         @(negedge clk); #1;
         chk(ctl_req == 1'b0, "R4", "partial burst not offered", 64'(ctl_req), 64'd0);
      end
      @(negedge clk);
      bus_beat(1'b1, 1'b0, 1'b0, 32'h0000_C000, 3'd3, 32'hC000_0002, unused);
      bus_beat(1'b1, 1'b0, 1'b1, 32'h0000_C000, 3'd3, 32'hC000_0003, unused);
      #1;
      chk(ctl_req == 1'b1, "R4", "complete burst offered", 64'(ctl_req), 64'd1);
      take_write("R4", 32'h0000_C000, 3'd3, 32'hC000_0000);

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule